// File: doc/BRIEF.md
# Oscillator Phase Path with Dither, Square and Sawtooth Outputs

This block is the phase half of a numerically controlled oscillator. A wide phase register adds an unsigned tuning word on every enabled sample clock and wraps around when it passes its top value. It can also take a one-cycle phase offset pulse that moves the phase once. The phase is cut down to a 16-bit table address, which feeds a sine/cosine table that lives outside this block. Before the cut, a pseudo-random value from a free-running shift register can be added to the low phase bits. This breaks up the periodic truncation error.

The same quantized phase also drives two waveform outputs: a square wave and a sawtooth, both 16-bit signed. These pass through a short delay line, so they line up in time with the sample that the external table returns for the same phase. A clock enable freezes every pipeline register. The dither generator keeps running while the pipeline is frozen.

Top module: `nco_phase_path`

## Requirements
- R1: On every rising clock edge with `en` high, the phase register adds the phase increment captured at the previous enabled edge, modulo 2^32.
- R2: A non-zero `phase_shift` captured at an enabled edge is added into the phase register exactly once, at the next enabled edge. For example, 0x20000000 moves `phase_addr` by 0x2000, which is 45 degrees.
- R3: `phase_addr` is bits [31:16] of (phase register + dither). With `DITHER_EN` = 0 the dither is zero, so `phase_addr` is just the top 16 bits of the phase register.
- R4: With `DITHER_EN` = 1, the dither is the low 16 bits of the shift-register state, zero-extended to 32 bits.
- R5: The dither shift register holds 32 bits. It loads `SEED` (non-zero) on reset and advances on every clock, whatever the state of `en`. Each step shifts the state left by one bit. The new bit 0 is the XOR of old bits 31, 6, 4, 2, 1 and 0, which matches the polynomial x^32+x^7+x^5+x^3+x^2+x+1.
- R6: While `en` is low, all pipeline registers and all outputs hold their values. When `en` returns high, processing resumes from the next sample.
- R7: An increment captured at enabled edge k reaches `phase_addr` at enabled edge k+2. It reaches `square_out` and `saw_out` at enabled edge k+4, which is the fifth enabled edge counting edge k.
- R8: `square_out` is +32767 (0x7FFF) when bit 15 of the phase it was computed from is 0, and -32768 (0x8000) when that bit is 1.
- R9: `saw_out` is the phase it was computed from with bit 15 inverted, read as a signed value.
- R10: While `rst_n` is low, the phase register and all pipeline stages clear. The outputs then show phase zero: `phase_addr` = 0, `square_out` = 32767 and `saw_out` = -32768.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Pipeline clock enable, active high |
| phase_inc | input | 32 | Unsigned tuning word added every enabled sample |
| phase_shift | input | 32 | Unsigned one-shot phase offset; zero when unused |
| phase_addr | output | 16 | Quantized phase, the address for the external sine/cosine table |
| square_out | output | 16 | Signed square-wave sample |
| saw_out | output | 16 | Signed sawtooth sample |

## Verification
The bench applies a quarter-turn increment that wraps the phase every four samples. This checks the modulo behaviour and both square-wave levels against a sawtooth crossing zero. It applies a single 45-degree shift pulse with zero increment, which shows whether the offset lands exactly once or keeps adding. It steps the increment from zero and counts edges, which separates the latency of the table address from the latency of the square and sawtooth outputs. A long run with a small increment, on a dithered and an undithered instance side by side, shows the carries that dither injects and checks that the generator keeps advancing while the enable holds the pipeline frozen.

// File: rtl/nco_pkg.sv
package nco_pkg;
  localparam int LFSR_W = 32;
  // feedback mask: bits 31,6,4,2,1,0 of the current state
  localparam logic [LFSR_W-1:0] LFSR_MASK = 32'h8000_0057;

  function automatic logic [LFSR_W-1:0] lfsr_step(input logic [LFSR_W-1:0] s);
    return {s[LFSR_W-2:0], ^(s & LFSR_MASK)};
  endfunction
endpackage

// File: rtl/nco_phase_acc.sv
module nco_phase_acc #(
  parameter int ACC_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [ACC_W-1:0] inc_i,
  input  logic [ACC_W-1:0] shift_i,
  output logic [ACC_W-1:0] acc_o
);
  logic [ACC_W-1:0] inc_q, inc_d;
  logic [ACC_W-1:0] shift_q, shift_d;
  logic [ACC_W-1:0] acc_q, acc_d;

  always_comb begin
    inc_d   = inc_q;
    shift_d = shift_q;
    acc_d   = acc_q;
    if (en) begin
      inc_d   = inc_i;
      shift_d = shift_i;
      acc_d   = acc_q + inc_q + shift_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inc_q   <= '0;
      shift_q <= '0;
      acc_q   <= '0;
    end else begin
      inc_q   <= inc_d;
      shift_q <= shift_d;
      acc_q   <= acc_d;
    end
  end

  assign acc_o = acc_q;

  // R6: a disabled edge leaves the phase register untouched
  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(acc_q));
  // R1: with zero increment and zero offset captured, phase does not move
  p_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (en && inc_q == '0 && shift_q == '0) |=> $stable(acc_q));
endmodule

// File: rtl/nco_dither_lfsr.sv
module nco_dither_lfsr #(
  parameter logic [31:0] SEED   = 32'h1D2C_5A3B,
  parameter int          DITH_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [DITH_W-1:0] dith_o
);
  import nco_pkg::*;

  logic [LFSR_W-1:0] state_q, state_d;

  always_comb state_d = lfsr_step(state_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= SEED;
    else        state_q <= state_d;
  end

  assign dith_o = state_q[DITH_W-1:0];

  // R5: a non-zero seed never reaches the all-zero lock-up state
  p_nonzero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    state_q != '0);
  // R5: the register shifts left by one on every clock
  p_shift_r5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> state_q[LFSR_W-1:1] == $past(state_q[LFSR_W-2:0]));
endmodule

// File: rtl/nco_quantizer.sv
module nco_quantizer #(
  parameter int ACC_W     = 32,
  parameter int ADDR_W    = 16,
  parameter int DITH_W    = 16,
  parameter bit DITHER_EN = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [ACC_W-1:0]  acc_i,
  input  logic [DITH_W-1:0] dith_i,
  output logic [ADDR_W-1:0] addr_o
);
  logic [ACC_W-1:0]  sum;
  logic [ADDR_W-1:0] addr_q, addr_d;

  generate
    if (DITHER_EN) begin : g_dith
      assign sum = acc_i + {{(ACC_W-DITH_W){1'b0}}, dith_i};
    end else begin : g_plain
      logic unused_dith;
      assign unused_dith = ^dith_i;
      assign sum = acc_i;
      // R3: without dither the address is the truncated phase
      p_trunc_r3: assert property (@(posedge clk) disable iff (!rst_n)
        en |=> addr_q == $past(acc_i[ACC_W-1 -: ADDR_W]));
    end
  endgenerate

  always_comb addr_d = en ? sum[ACC_W-1 -: ADDR_W] : addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) addr_q <= '0;
    else        addr_q <= addr_d;
  end

  assign addr_o = addr_q;

  // R6: address frozen while disabled
  p_addr_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(addr_q));
endmodule

// File: rtl/nco_wave_delay.sv
module nco_wave_delay #(
  parameter int ADDR_W = 16,
  parameter int DEPTH  = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     en,
  input  logic [ADDR_W-1:0]        addr_i,
  output logic signed [ADDR_W-1:0] square_o,
  output logic signed [ADDR_W-1:0] saw_o
);
  localparam logic [ADDR_W-1:0] SQ_HI = {1'b0, {(ADDR_W-1){1'b1}}};
  localparam logic [ADDR_W-1:0] SQ_LO = {1'b1, {(ADDR_W-1){1'b0}}};

  logic [ADDR_W-1:0] sq_src  [DEPTH];
  logic [ADDR_W-1:0] saw_src [DEPTH];
  logic [ADDR_W-1:0] sq_q    [DEPTH];
  logic [ADDR_W-1:0] saw_q   [DEPTH];

  generate
    for (genvar g = 0; g < DEPTH; g++) begin : g_stage
      logic [ADDR_W-1:0] sq_d, saw_d;
      if (g == 0) begin : g_head
        assign sq_src[g]  = addr_i[ADDR_W-1] ? SQ_LO : SQ_HI;
        assign saw_src[g] = {~addr_i[ADDR_W-1], addr_i[ADDR_W-2:0]};
      end else begin : g_tail
        assign sq_src[g]  = sq_q[g-1];
        assign saw_src[g] = saw_q[g-1];
      end

      always_comb begin
        sq_d  = en ? sq_src[g]  : sq_q[g];
        saw_d = en ? saw_src[g] : saw_q[g];
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          sq_q[g]  <= SQ_HI;
          saw_q[g] <= SQ_LO;
        end else begin
          sq_q[g]  <= sq_d;
          saw_q[g] <= saw_d;
        end
      end
    end
  endgenerate

  assign square_o = sq_q[DEPTH-1];
  assign saw_o    = saw_q[DEPTH-1];

  // R8/R9: square level must agree with the sawtooth half it belongs to
  p_sq_saw_pair_r8: assert property (@(posedge clk) disable iff (!rst_n)
    square_o == (saw_o[ADDR_W-1] ? SQ_HI : SQ_LO));
  // R8: square only takes its two extreme levels
  p_sq_levels_r8: assert property (@(posedge clk) disable iff (!rst_n)
    square_o == SQ_HI || square_o == SQ_LO);
  // R6: outputs frozen while disabled
  p_out_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(square_o) && $stable(saw_o));
endmodule

// File: rtl/nco_phase_path.sv
module nco_phase_path #(
  parameter int          ACC_W     = 32,
  parameter int          ADDR_W    = 16,
  parameter bit          DITHER_EN = 1'b0,
  parameter logic [31:0] SEED      = 32'h1D2C_5A3B,
  parameter int          TABLE_LAT = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     en,
  input  logic [ACC_W-1:0]         phase_inc,
  input  logic [ACC_W-1:0]         phase_shift,
  output logic [ADDR_W-1:0]        phase_addr,
  output logic signed [ADDR_W-1:0] square_out,
  output logic signed [ADDR_W-1:0] saw_out
);
  localparam int DITH_W = ADDR_W;

  logic [ACC_W-1:0]  acc;
  logic [DITH_W-1:0] dith;

  nco_phase_acc #(.ACC_W(ACC_W)) u_acc (
    .clk(clk), .rst_n(rst_n), .en(en),
    .inc_i(phase_inc), .shift_i(phase_shift), .acc_o(acc)
  );

  generate
    if (DITHER_EN) begin : g_lfsr
      nco_dither_lfsr #(.SEED(SEED), .DITH_W(DITH_W)) u_lfsr (
        .clk(clk), .rst_n(rst_n), .dith_o(dith)
      );
    end else begin : g_nolfsr
      assign dith = '0;
    end
  endgenerate

  nco_quantizer #(
    .ACC_W(ACC_W), .ADDR_W(ADDR_W), .DITH_W(DITH_W), .DITHER_EN(DITHER_EN)
  ) u_quant (
    .clk(clk), .rst_n(rst_n), .en(en),
    .acc_i(acc), .dith_i(dith), .addr_o(phase_addr)
  );

  nco_wave_delay #(.ADDR_W(ADDR_W), .DEPTH(TABLE_LAT)) u_wave (
    .clk(clk), .rst_n(rst_n), .en(en),
    .addr_i(phase_addr), .square_o(square_out), .saw_o(saw_out)
  );
endmodule

// File: tb/nco_phase_path_tb.sv
module nco_phase_path_tb;
  localparam logic [31:0] TB_SEED = 32'h1D2C_5A3B;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0;
  logic [31:0] phase_inc = '0;
  logic [31:0] phase_shift = '0;
  logic [15:0] addr_a, addr_b;
  logic signed [15:0] sq_a, saw_a, sq_b, saw_b;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  nco_phase_path #(.DITHER_EN(1'b0)) u_dut (
    .clk(clk), .rst_n(rst_n), .en(en), .phase_inc(phase_inc),
    .phase_shift(phase_shift), .phase_addr(addr_a),
    .square_out(sq_a), .saw_out(saw_a)
  );

  nco_phase_path #(.DITHER_EN(1'b1), .SEED(TB_SEED)) u_dut_dith (
    .clk(clk), .rst_n(rst_n), .en(en), .phase_inc(phase_inc),
    .phase_shift(phase_shift), .phase_addr(addr_b),
    .square_out(sq_b), .saw_out(saw_b)
  );

  // reference model built from the requirements
  function automatic logic [31:0] adv(input logic [31:0] s);
    return {s[30:0], s[31] ^ s[6] ^ s[4] ^ s[2] ^ s[1] ^ s[0]};
  endfunction
  function automatic logic [15:0] top16(input logic [31:0] v);
    return v[31:16];
  endfunction
  function automatic logic [15:0] sq_of(input logic [15:0] a);
    return a[15] ? 16'h8000 : 16'h7FFF;
  endfunction

  logic [31:0] m_inc, m_sh, m_acc, m_lfsr;
  logic [15:0] m_a3, m_a4, m_a5, m_x3, m_x4, m_x5;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_inc <= '0; m_sh <= '0; m_acc <= '0; m_lfsr <= TB_SEED;
      m_a3 <= '0; m_a4 <= '0; m_a5 <= '0;
      m_x3 <= '0; m_x4 <= '0; m_x5 <= '0;
    end else begin
      m_lfsr <= adv(m_lfsr);
      if (en) begin
        m_inc <= phase_inc;
        m_sh  <= phase_shift;
        m_acc <= m_acc + m_inc + m_sh;
        m_a3  <= top16(m_acc);
        m_x3  <= top16(m_acc + {16'h0, m_lfsr[15:0]});
        m_a4  <= m_a3; m_a5 <= m_a4;
        m_x4  <= m_x3; m_x5 <= m_x4;
      end
    end
  end

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cmp_model(input string req);
    chk({req, " addr"}, addr_a, m_a3);
    chk({req, " square"}, sq_a, sq_of(m_a5));
    chk({req, " saw"}, saw_a, m_a5 ^ 16'h8000);
    chk({req, " dith addr"}, addr_b, m_x3);
    chk({req, " dith square"}, sq_b, sq_of(m_x5));
    chk({req, " dith saw"}, saw_b, m_x5 ^ 16'h8000);
  endtask

  task automatic do_reset(input logic [31:0] inc);
    @(negedge clk);
    rst_n = 1'b0; en = 1'b1; phase_inc = inc; phase_shift = '0;
    repeat (2) @(negedge clk);
    chk("R10 reset addr", addr_a, 16'h0000);
    chk("R10 reset square", sq_a, 16'h7FFF);
    chk("R10 reset saw", saw_a, 16'h8000);
    chk("R10 reset dith addr", addr_b, 16'h0000);
    rst_n = 1'b1;
  endtask

  task automatic t_wrap();
    do_reset(32'h4000_0000);
    repeat (3) @(negedge clk);
    chk("R1 edge3", addr_a, 16'h4000);
    @(negedge clk); chk("R1 edge4", addr_a, 16'h8000);
    @(negedge clk); chk("R1 edge5", addr_a, 16'hC000);
    chk("R8 square at phase 0x4000", sq_a, 16'h7FFF);
    @(negedge clk); chk("R1 wrap edge6", addr_a, 16'h0000);
    chk("R8 square at phase 0x8000", sq_a, 16'h8000);
    chk("R9 saw at phase 0x8000", saw_a, 16'h0000);
    @(negedge clk);
    chk("R9 saw at phase 0xC000", saw_a, 16'h4000);
    cmp_model("R1 model");
  endtask

  task automatic t_shift();
    do_reset(32'h0);
    repeat (3) @(negedge clk);
    phase_shift = 32'h2000_0000;
    @(negedge clk);
    phase_shift = '0;
    repeat (5) @(negedge clk);
    chk("R2 45deg shift", addr_a, 16'h2000);
    repeat (5) @(negedge clk);
    chk("R2 shift applied once", addr_a, 16'h2000);
    cmp_model("R2 model");
  endtask

  task automatic t_latency();
    // continues from the 0x2000 state left by t_shift
    phase_inc = 32'h0001_0000;
    @(negedge clk);
    @(negedge clk); chk("R7 addr before k+2", addr_a, 16'h2000);
    @(negedge clk); chk("R7 addr at k+2", addr_a, 16'h2001);
    @(negedge clk); chk("R7 saw before k+4", saw_a, 16'hA000);
    @(negedge clk); chk("R7 saw at k+4", saw_a, 16'hA001);
    cmp_model("R7 model");
  endtask

  task automatic t_dither();
    int diff;
    diff = 0;
    do_reset(32'h0003_1F00);
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      cmp_model("R3 R4 R5 run");
      if (addr_a != addr_b) diff++;
    end
    n_chk++;
    if (diff == 0) begin
      n_bad++;
      $display("FAIL R4 dither never changed address: actual %0d expected >0", diff);
    end
  endtask

  task automatic t_freeze();
    logic [15:0] ha, hb, hs, hw;
    do_reset(32'h0123_4567);
    repeat (20) @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    ha = addr_a; hb = addr_b; hs = sq_a; hw = saw_a;
    for (int i = 0; i < 8; i++) begin
      phase_inc = 32'hFFFF_0000;
      @(negedge clk);
      chk("R6 frozen addr", addr_a, ha);
      chk("R6 frozen dith addr", addr_b, hb);
      chk("R6 frozen square", sq_a, hs);
      chk("R6 frozen saw", saw_a, hw);
    end
    phase_inc = 32'h0123_4567;
    en = 1'b1;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      cmp_model("R6 R5 resume");
    end
  endtask

  initial begin
    t_wrap();
    t_shift();
    t_latency();
    t_dither();
    t_freeze();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule